// File: doc/BRIEF.md
# Tri-port latched bus exchanger

This block joins a 12-bit host-side port with two 12-bit memory-side ports, one serving the even bank and one the odd bank. Traffic in each of the four directions passes through its own level-sensitive holding stage. Two stages carry host data out to the even and odd ports, so one host word can be sent to one bank or to both at once. Two more stages carry bank data back, and a select input chooses which of these two drives the host port. The block serves interleaved memory access and address multiplexing.

Each port has a plain data input, a data output and a drive flag. Each port also has its own active-low output enable, and the drive flag is the inverse of that enable. A holding stage is open while its enable input is high. While it is open, its output follows its input in the same cycle with no register on the path. The stage stores its input at every rising clock edge on which the enable is high. When the enable goes low, the output shows that stored value until the enable rises again. An active-low reset clears all four stored values to zero.

Top module: `tri_port_exchanger`

## Requirements
- R1: While `a2b1_open` is 1, `b1_out` equals `a_in` in the same cycle.
- R2: While `a2b2_open` is 1, `b2_out` equals `a_in` in the same cycle. Both host-to-bank stages may be open together, and then both bank outputs carry the host word.
- R3: While the selected bank-to-host stage is open, `a_out` equals that bank's input in the same cycle. The stage fed by `b1_in` is controlled by `b12a_open`, and the stage fed by `b2_in` is controlled by `b22a_open`.
- R4: Once a host-to-bank enable has been sampled low at a rising edge, the bank output keeps the value `a_in` had at the last rising edge where that enable was 1. Later changes of `a_in` do not alter it until the enable is 1 again.
- R5: `pick_b1` = 1 routes the even-bank return stage (fed from `b1_in`) to `a_out`. `pick_b1` = 0 routes the odd-bank return stage (fed from `b2_in`) to `a_out`. Toggling `pick_b1` while both return stages are closed switches `a_out` between their two stored values.
- R6: `a_drv`, `b1_drv` and `b2_drv` are the inverses of `a_oe_n`, `b1_oe_n` and `b2_oe_n`. All eight combinations of the three enables are legal, and the enables have no effect on any data output.
- R7: While `rst_n` is 0, all four stored values are zero, so every output whose stage is closed reads zero.
- R8: A closed bank-to-host stage ignores changes on its bank input, and `a_out` keeps the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at which the holding stages store |
| rst_n | input | 1 | Active-low reset, clears all stored values |
| a_in | input | 12 | Host port data in |
| a_out | output | 12 | Host port data out (selected return stage) |
| a_drv | output | 1 | Host port drive flag |
| b1_in | input | 12 | Even-bank port data in |
| b1_out | output | 12 | Even-bank port data out |
| b1_drv | output | 1 | Even-bank port drive flag |
| b2_in | input | 12 | Odd-bank port data in |
| b2_out | output | 12 | Odd-bank port data out |
| b2_drv | output | 1 | Odd-bank port drive flag |
| a2b1_open | input | 1 | Host-to-even stage open while 1 |
| a2b2_open | input | 1 | Host-to-odd stage open while 1 |
| b12a_open | input | 1 | Even-to-host stage open while 1 |
| b22a_open | input | 1 | Odd-to-host stage open while 1 |
| pick_b1 | input | 1 | Return select: 1 even bank, 0 odd bank |
| a_oe_n | input | 1 | Host port output enable, active low |
| b1_oe_n | input | 1 | Even-bank output enable, active low |
| b2_oe_n | input | 1 | Odd-bank output enable, active low |

## Verification
Transparent paths, the return select and the drive flags are all combinational, so their results are due in the same cycle as the stimulus. Held values come from a register that loads at the rising edge, so a held value appears one edge after the last cycle in which its enable was high. The bench applies every input change just after a falling edge and compares 1 ns later. At that point its own model has already taken the preceding rising edge, so both the same-cycle results and the one-edge results are settled. The sweep covers all sixteen enable patterns, both select values and all eight output-enable combinations. Directed sequences then cover holding and select switching.

// File: rtl/tri_port_exchanger.sv
module tri_port_exchanger #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_drv,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_drv,
  input  logic         a2b1_open,
  input  logic         a2b2_open,
  input  logic         b12a_open,
  input  logic         b22a_open,
  input  logic         pick_b1,
  input  logic         a_oe_n,
  input  logic         b1_oe_n,
  input  logic         b2_oe_n
);
  localparam int LANES = 4;

  logic [W-1:0] lane_d [LANES];
  logic [W-1:0] lane_q [LANES];
  logic [W-1:0] lane_y [LANES];
  logic         lane_en[LANES];

  assign lane_d[0] = a_in;  assign lane_en[0] = a2b1_open;
  assign lane_d[1] = a_in;  assign lane_en[1] = a2b2_open;
  assign lane_d[2] = b1_in; assign lane_en[2] = b12a_open;
  assign lane_d[3] = b2_in; assign lane_en[3] = b22a_open;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           lane_q[g] <= '0;
      else if (lane_en[g])  lane_q[g] <= lane_d[g];
    end
    assign lane_y[g] = lane_en[g] ? lane_d[g] : lane_q[g];
  end

  assign b1_out = lane_y[0];
  assign b2_out = lane_y[1];
  assign a_out  = pick_b1 ? lane_y[2] : lane_y[3];

  assign a_drv  = ~a_oe_n;
  assign b1_drv = ~b1_oe_n;
  assign b2_drv = ~b2_oe_n;
endmodule

module tri_port_exchanger_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_drv,
  input logic [W-1:0] b1_in,
  input logic [W-1:0] b1_out,
  input logic         b1_drv,
  input logic [W-1:0] b2_in,
  input logic [W-1:0] b2_out,
  input logic         b2_drv,
  input logic         a2b1_open,
  input logic         a2b2_open,
  input logic         b12a_open,
  input logic         b22a_open,
  input logic         pick_b1,
  input logic         a_oe_n,
  input logic         b1_oe_n,
  input logic         b2_oe_n
);
  // R1
  b1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a2b1_open |-> b1_out == a_in);
  // R2
  b2_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a2b2_open |-> b2_out == a_in);
  // R3
  ret_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_b1 ? b12a_open : b22a_open) |-> a_out == (pick_b1 ? b1_in : b2_in));
  // R4
  b1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a2b1_open && $past(!a2b1_open)) |-> $stable(b1_out));
  // R4
  b2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a2b2_open && $past(!a2b2_open)) |-> $stable(b2_out));
  // R8
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!b12a_open && !b22a_open && $past(!b12a_open) && $past(!b22a_open)
     && $stable(pick_b1)) |-> $stable(a_out));
  // R6
  drive_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drv != a_oe_n) && (b1_drv != b1_oe_n) && (b2_drv != b2_oe_n));
endmodule

bind tri_port_exchanger tri_port_exchanger_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
  .b1_in(b1_in), .b1_out(b1_out), .b1_drv(b1_drv),
  .b2_in(b2_in), .b2_out(b2_out), .b2_drv(b2_drv),
  .a2b1_open(a2b1_open), .a2b2_open(a2b2_open),
  .b12a_open(b12a_open), .b22a_open(b22a_open),
  .pick_b1(pick_b1), .a_oe_n(a_oe_n), .b1_oe_n(b1_oe_n), .b2_oe_n(b2_oe_n)
);

// File: tb/sim_tri_port_exchanger.sv
module sim_tri_port_exchanger;
  localparam int W = 12;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_drv, b1_drv, b2_drv;
  logic a2b1_open = 0, a2b2_open = 0, b12a_open = 0, b22a_open = 0;
  logic pick_b1 = 0, a_oe_n = 1, b1_oe_n = 1, b2_oe_n = 1;
  int n_chk = 0, n_bad = 0;
  logic [W-1:0] m0, m1, m2, m3;

  always #2 clk = ~clk;

  tri_port_exchanger #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b1_in(b1_in), .b1_out(b1_out), .b1_drv(b1_drv),
    .b2_in(b2_in), .b2_out(b2_out), .b2_drv(b2_drv),
    .a2b1_open(a2b1_open), .a2b2_open(a2b2_open),
    .b12a_open(b12a_open), .b22a_open(b22a_open),
    .pick_b1(pick_b1), .a_oe_n(a_oe_n), .b1_oe_n(b1_oe_n), .b2_oe_n(b2_oe_n));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m0 <= '0; m1 <= '0; m2 <= '0; m3 <= '0; end
    else begin
      if (a2b1_open) m0 <= a_in;
      if (a2b2_open) m1 <= a_in;
      if (b12a_open) m2 <= b1_in;
      if (b22a_open) m3 <= b2_in;
    end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [W-1:0] e1, e2, ea;
    e1 = a2b1_open ? a_in : m0;
    e2 = a2b2_open ? a_in : m1;
    ea = pick_b1 ? (b12a_open ? b1_in : m2) : (b22a_open ? b2_in : m3);
    chk(a2b1_open ? (a2b2_open ? "R2 b1_out" : "R1 b1_out") : "R4 b1_out", b1_out, e1);
    chk(a2b2_open ? "R2 b2_out" : "R4 b2_out", b2_out, e2);
    chk((pick_b1 ? b12a_open : b22a_open) ? "R3 a_out" : "R8 a_out", a_out, ea);
    chk("R6 a_drv",  {{(W-1){1'b0}}, a_drv},  {{(W-1){1'b0}}, ~a_oe_n});
    chk("R6 b1_drv", {{(W-1){1'b0}}, b1_drv}, {{(W-1){1'b0}}, ~b1_oe_n});
    chk("R6 b2_drv", {{(W-1){1'b0}}, b2_drv}, {{(W-1){1'b0}}, ~b2_oe_n});
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    a_in = 12'hABC; b1_in = 12'h123; b2_in = 12'h456;
    repeat (3) step();
    #1;
    chk("R7 b1_out reset", b1_out, '0);
    chk("R7 b2_out reset", b2_out, '0);
    chk("R7 a_out reset", a_out, '0);
    pick_b1 = 1; #1;
    chk("R7 a_out reset sel1", a_out, '0);
    step(); rst_n = 1;

    // sweep: enables, select, output enables
    for (int i = 0; i < 512; i++) begin
      step();
      a_in  = W'((i * 173 + 29) & 12'hFFF);
      b1_in = W'((i * 91 + 7) & 12'hFFF);
      b2_in = W'((i * 59 + 300) & 12'hFFF);
      {a2b1_open, a2b2_open, b12a_open, b22a_open} = 4'(i);
      pick_b1 = i[4];
      {a_oe_n, b1_oe_n, b2_oe_n} = 3'(i >> 5);
      #1 check_all();
    end

    // R4: capture then hold while a_in moves
    step(); a2b1_open = 1; a2b2_open = 1; a_in = 12'h5A5; #1 check_all();
    step(); a2b1_open = 0; a_in = 12'h0F0; #1;
    chk("R4 b1 holds 5A5", b1_out, 12'h5A5);
    chk("R2 b2 follows", b2_out, 12'h0F0);
    step(); a2b2_open = 0; a_in = 12'h777; #1;
    chk("R4 b1 still 5A5", b1_out, 12'h5A5);
    chk("R4 b2 holds 0F0", b2_out, 12'h0F0);

    // R5/R8: distinct values in both return stages, then toggle select
    step(); b12a_open = 1; b22a_open = 1; b1_in = 12'h111; b2_in = 12'h222;
    step(); b12a_open = 0; b22a_open = 0; b1_in = 12'hEEE; b2_in = 12'hDDD;
    for (int k = 0; k < 6; k++) begin
      step(); pick_b1 = k[0]; b1_in = W'(k * 3); b2_in = W'(k * 5); #1;
      chk(pick_b1 ? "R5 sel even" : "R5 sel odd", a_out, pick_b1 ? 12'h111 : 12'h222);
      chk("R8 ignores bank input", a_out, pick_b1 ? m2 : m3);
    end

    // R6: enables leave data outputs untouched
    for (int k = 0; k < 8; k++) begin
      step(); {a_oe_n, b1_oe_n, b2_oe_n} = 3'(k); #1;
      check_all();
      chk("R6 data unaffected b1", b1_out, 12'h5A5);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule